// File: doc/BRIEF.md
# Hardware Ticket Lock Unit

This block is a shared lock for a fixed number of requesting agents that hands out the lock in strict order of arrival. It keeps two counters: an issue counter that counts the tickets handed out, and a serving counter that counts the completed releases. An agent asks for the lock by pulsing its request line. That request performs an atomic fetch-and-increment on the issue counter, and the value the counter held before the increment comes back to the agent as its ticket. The agent owns the lock while the serving counter equals its ticket. A release strobe advances the serving counter by one and so passes the lock to the next ticket in line.

Each agent has a slot that stores its ticket and drives a grant line, plus a poll port that returns the current serving value one cycle after the poll. Requests that arrive in the same cycle are serialised by agent index, lowest index first, inside one atomic update. Both counters are ceil(log2 P)+1 bits wide and wrap around. Because an agent can hold only one ticket at a time, the wrap never makes two tickets look alike.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset the issue and serving counters are zero, `held_o` is 0, and no `grant_o`, `tkt_vld_o`, `rel_err_o` or `poll_vld_o` bit is set.
- R2: A request from an agent that holds no ticket pulses that agent's `tkt_vld_o` bit in the following cycle. From then on its `tkt_o` field (agent i at bits [i*TW +: TW]) holds the issue-counter value from before the increment.
- R3: When several agents are accepted in the same cycle, they receive consecutive tickets in ascending agent-index order. The issue counter advances by the number accepted.
- R4: A request from an agent that already holds a ticket is ignored: no `tkt_vld_o` pulse, no change to its ticket, no advance of the issue counter.
- R5: `grant_o[i]` is 1 exactly when agent i holds a ticket equal to the serving counter, so at most one grant is active, and none while the lock is free.
- R6: A release while the lock is held increments the serving counter by one. It also frees the granted agent's slot, so that agent may request again.
- R7: A release while the lock is free (serving equals issue counter) is ignored: the serving counter does not change, and `rel_err_o` pulses for one cycle in the next cycle.
- R8: Grants follow strict first-come order of ticket issue, so every waiting agent is granted after at most P-1 releases.
- R9: Both counters wrap modulo 2^TW, where TW = ceil(log2 P)+1. Ticket comparison stays correct across the wrap.
- R10: A poll by agent i pulses `poll_vld_o[i]` in the next cycle. Its `poll_val_o` field (bits [i*TW +: TW]) then holds the serving value as it stood at the polling edge.
- R11: `held_o` is 1 exactly when the serving counter differs from the issue counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_AGENTS | Per-agent fetch-and-increment request, one bit per agent |
| tkt_vld_o | output | N_AGENTS | Per-agent one-cycle ticket-return pulse |
| tkt_o | output | N_AGENTS*TW | Per-agent stored ticket |
| grant_o | output | N_AGENTS | Per-agent lock-owned indication |
| rel_i | input | 1 | Release strobe |
| rel_err_o | output | 1 | Pulse for a release issued while the lock was free |
| poll_i | input | N_AGENTS | Per-agent poll of the serving counter |
| poll_vld_o | output | N_AGENTS | Per-agent poll-response pulse |
| poll_val_o | output | N_AGENTS*TW | Per-agent returned serving value |
| serve_o | output | TW | Current serving counter |
| held_o | output | 1 | Lock held (counters differ) |

## Verification
On every cycle the assertions check these properties: at most one grant is active, and none while the lock is free. The issue counter steps by exactly the number of accepted requests. The serving counter steps by one on a legal release and holds still otherwise. An illegal release raises the error flag, and each poll and each accepted request brings its response pulse one cycle later. First-come order across many acquisitions, the exact ticket values handed to simultaneous requesters, and correct matching after both counters wrap show only in the bench's scenarios. There, a reference model follows every ticket from issue to release.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

  // Number of set bits of v strictly below position idx (v up to 32 agents).
  function automatic int unsigned ones_below(input logic [31:0] v, input int unsigned idx);
    int unsigned c;
    c = 0;
    for (int unsigned j = 0; j < 32; j++) begin
      if (j < idx && v[j]) c++;
    end
    return c;
  endfunction

  // Counter width for a given agent count: ceil(log2 P) + 1.
  function automatic int unsigned tkt_width(input int unsigned agents);
    return $clog2(agents) + 1;
  endfunction

endpackage

// File: rtl/tlu_issue.sv
module tlu_issue #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned TW       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_AGENTS-1:0]    acc_req,
  output logic [TW-1:0]          nxt_q,
  output logic [N_AGENTS*TW-1:0] tkt_d
);
  import tlu_pkg::*;

  logic [TW-1:0] nxt_d;

  // Fetch-and-increment: every accepted agent sees the old value plus its rank.
  for (genvar i = 0; i < N_AGENTS; i++) begin : g_rank
    assign tkt_d[i*TW +: TW] = nxt_q + TW'(ones_below(32'(acc_req), i));
  end

  assign nxt_d = nxt_q + TW'($countones(acc_req));

  always_ff @(posedge clk) begin
    if (!rst_n) nxt_q <= '0;
    else        nxt_q <= nxt_d;
  end
endmodule

// File: rtl/tlu_serve.sv
module tlu_serve #(
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rel_i,
  input  logic [TW-1:0] nxt_q,
  output logic [TW-1:0] srv_q,
  output logic          held,
  output logic          rel_ok,
  output logic          rel_err_q
);
  assign held   = (srv_q != nxt_q);
  assign rel_ok = rel_i && held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srv_q     <= '0;
      rel_err_q <= 1'b0;
    end else begin
      if (rel_ok) srv_q <= srv_q + TW'(1);
      rel_err_q <= rel_i && !held;
    end
  end
endmodule

// File: rtl/tlu_slot.sv
module tlu_slot #(
  parameter int unsigned TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [TW-1:0] tkt_in,
  input  logic          rel_ok,
  input  logic [TW-1:0] srv_q,
  input  logic          poll,
  output logic          has_q,
  output logic [TW-1:0] tkt_q,
  output logic          grant,
  output logic          tkt_vld_q,
  output logic          poll_vld_q,
  output logic [TW-1:0] poll_val_q
);
  assign grant = has_q && (tkt_q == srv_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_q      <= 1'b0;
      tkt_q      <= '0;
      tkt_vld_q  <= 1'b0;
      poll_vld_q <= 1'b0;
      poll_val_q <= '0;
    end else begin
      tkt_vld_q  <= acc;
      poll_vld_q <= poll;
      if (poll) poll_val_q <= srv_q;
      if (acc) begin
        has_q <= 1'b1;
        tkt_q <= tkt_in;
      end else if (rel_ok && grant) begin
        has_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned TW       = tlu_pkg::tkt_width(N_AGENTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_AGENTS-1:0]    req_i,
  output logic [N_AGENTS-1:0]    tkt_vld_o,
  output logic [N_AGENTS*TW-1:0] tkt_o,
  output logic [N_AGENTS-1:0]    grant_o,
  input  logic                   rel_i,
  output logic                   rel_err_o,
  input  logic [N_AGENTS-1:0]    poll_i,
  output logic [N_AGENTS-1:0]    poll_vld_o,
  output logic [N_AGENTS*TW-1:0] poll_val_o,
  output logic [TW-1:0]          serve_o,
  output logic                   held_o
);
  // Named internal events, visible to the bound checker.
  logic [N_AGENTS-1:0]    has_vec;
  logic [N_AGENTS-1:0]    acc_req;
  logic [N_AGENTS*TW-1:0] tkt_d;
  logic [TW-1:0]          nxt;
  logic [TW-1:0]          srv;
  logic                   rel_ok;

  assign acc_req = req_i & ~has_vec;

  tlu_issue #(.N_AGENTS(N_AGENTS), .TW(TW)) u_issue (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .nxt_q(nxt), .tkt_d(tkt_d)
  );

  tlu_serve #(.TW(TW)) u_serve (
    .clk(clk), .rst_n(rst_n), .rel_i(rel_i), .nxt_q(nxt),
    .srv_q(srv), .held(held_o), .rel_ok(rel_ok), .rel_err_q(rel_err_o)
  );

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_slot
    tlu_slot #(.TW(TW)) u_slot (
      .clk(clk), .rst_n(rst_n), .acc(acc_req[i]), .tkt_in(tkt_d[i*TW +: TW]),
      .rel_ok(rel_ok), .srv_q(srv), .poll(poll_i[i]),
      .has_q(has_vec[i]), .tkt_q(tkt_o[i*TW +: TW]), .grant(grant_o[i]),
      .tkt_vld_q(tkt_vld_o[i]), .poll_vld_q(poll_vld_o[i]),
      .poll_val_q(poll_val_o[i*TW +: TW])
    );
  end

  assign serve_o = srv;
endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
  parameter int unsigned N_AGENTS = 4,
  parameter int unsigned TW       = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_AGENTS-1:0] acc_req,
  input logic [N_AGENTS-1:0] tkt_vld_o,
  input logic [N_AGENTS-1:0] grant_o,
  input logic                rel_i,
  input logic                rel_err_o,
  input logic [N_AGENTS-1:0] poll_i,
  input logic [N_AGENTS-1:0] poll_vld_o,
  input logic [TW-1:0]       serve_o,
  input logic [TW-1:0]       nxt,
  input logic                held_o
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R5
  AST_NO_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !held_o |-> grant_o == '0); // R5
  AST_ISSUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> nxt == TW'($past(nxt) + TW'($countones($past(acc_req))))); // R3
  AST_ISSUE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tkt_vld_o == $past(acc_req)); // R4
  AST_SERVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_i && held_o) |=> serve_o == TW'($past(serve_o) + TW'(1))); // R6
  AST_SERVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_i && held_o) |=> $stable(serve_o)); // R7
  AST_REL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_i && !held_o) |=> rel_err_o); // R7
  AST_POLL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> poll_vld_o == $past(poll_i)); // R10
endmodule

bind ticket_lock_unit tlu_checker #(.N_AGENTS(N_AGENTS), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .tkt_vld_o(tkt_vld_o),
  .grant_o(grant_o), .rel_i(rel_i), .rel_err_o(rel_err_o), .poll_i(poll_i),
  .poll_vld_o(poll_vld_o), .serve_o(serve_o), .nxt(nxt), .held_o(held_o)
);

// File: tb/sim_ticket_lock_unit.sv
`timescale 1ns/1ps
module sim_ticket_lock_unit;
  localparam int N  = 4;
  localparam int TW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0, poll = '0;
  logic            rel = 1'b0;
  logic [N-1:0]    tkt_vld, grant, poll_vld;
  logic [N*TW-1:0] tkt, poll_val;
  logic [TW-1:0]   serve;
  logic            rel_err, held;

  int n_chk = 0, n_bad = 0;

  // Reference model state
  logic [TW-1:0] m_next = '0, m_serve = '0;
  logic [N-1:0]  m_has = '0, m_vld = '0, m_poll = '0;
  logic [TW-1:0] m_tkt [N];
  logic [TW-1:0] m_pval [N];
  logic          m_err = 1'b0;

  always #5 clk = ~clk;

  ticket_lock_unit #(.N_AGENTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .tkt_vld_o(tkt_vld), .tkt_o(tkt),
    .grant_o(grant), .rel_i(rel), .rel_err_o(rel_err), .poll_i(poll),
    .poll_vld_o(poll_vld), .poll_val_o(poll_val), .serve_o(serve), .held_o(held)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_grant();
    logic [N-1:0] g;
    for (int i = 0; i < N; i++) g[i] = m_has[i] && (m_tkt[i] == m_serve);
    return g;
  endfunction

  // Apply one cycle of stimulus, advance the model, check after the edge.
  task automatic step(input logic [N-1:0] r, input logic rl, input logic [N-1:0] p);
    logic [N-1:0] acc, g;
    logic         hld;
    int           rank;
    @(negedge clk);
    req = r; rel = rl; poll = p;
    g   = m_grant();
    hld = (m_serve != m_next);
    acc = r & ~m_has;
    rank = 0;
    for (int i = 0; i < N; i++) begin
      if (p[i]) m_pval[i] = m_serve;
      if (acc[i]) begin
        m_tkt[i] = m_next + TW'(rank);
        m_has[i] = 1'b1;
        rank++;
      end else if (rl && hld && g[i]) begin
        m_has[i] = 1'b0;
      end
    end
    m_next = m_next + TW'(rank);
    if (rl && hld) m_serve = m_serve + TW'(1);
    m_err = rl && !hld;
    m_vld = acc; m_poll = p;
    @(posedge clk); #1;
    req = '0; rel = 1'b0; poll = '0;
    chk(tkt_vld == m_vld, "R2/R4 tkt_vld", int'(tkt_vld), int'(m_vld));
    for (int i = 0; i < N; i++) begin
      if (m_vld[i]) chk(tkt[i*TW +: TW] == m_tkt[i], "R2/R3/R9 ticket value",
                        int'(tkt[i*TW +: TW]), int'(m_tkt[i]));
      if (m_poll[i]) chk(poll_val[i*TW +: TW] == m_pval[i], "R10 poll value",
                         int'(poll_val[i*TW +: TW]), int'(m_pval[i]));
    end
    chk(poll_vld == m_poll, "R10 poll pulse", int'(poll_vld), int'(m_poll));
    chk(grant == m_grant(), "R5/R8 grant FIFO", int'(grant), int'(m_grant()));
    chk(serve == m_serve, "R6/R7/R9 serving", int'(serve), int'(m_serve));
    chk(held == (m_serve != m_next), "R11 held", int'(held), int'(m_serve != m_next));
    chk(rel_err == m_err, "R7 rel_err", int'(rel_err), int'(m_err));
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_tkt[i] = '0; m_pval[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(serve == 0 && held == 0 && grant == 0 && tkt_vld == 0, "R1 reset",
        int'(serve) + int'(grant), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rel_err == 0 && poll_vld == 0 && held == 0, "R1 after reset", int'(held), 0);

    step('0, 1'b1, 4'b0001);       // R7 release while free
    step(4'b0100, 1'b0, '0);       // R2 single request -> ticket 0, grant
    step(4'b1011, 1'b0, 4'b1111);  // R3 simultaneous -> 1,2,3 in index order
    step(4'b1111, 1'b0, '0);       // R4 all already hold tickets
    for (int k = 0; k < 4; k++) step('0, 1'b1, 4'b0010); // R6/R8 FIFO drain
    step('0, 1'b1, '0);            // R7 lock free again
    // R9: repeated full rounds drive both counters around the wrap
    for (int k = 0; k < 6; k++) begin
      step(4'b1111, 1'b0, '0);
      for (int j = 0; j < 4; j++) step('0, 1'b1, '0);
    end
    void'($urandom(32'd20240611));
    for (int k = 0; k < 600; k++)
      step(N'($urandom), ($urandom % 3) == 0, N'($urandom));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule